// File: doc/BRIEF.md
# Phase-Offset PWM Channel on a Shared Modulus Timebase

This block produces one pulse-width-modulated output. The output gets its timing from a modulus up-counter that other channels can share, so all of them keep the same period and stay in step. A global prescaler and a channel prescaler slow the counting rate. The counter runs from 0 to one less than the programmed period, then returns to 0. The running count and the wrap strobe are block outputs, so neighbouring channels can follow the same timebase.

The active part of each period starts when the count reaches a programmable phase offset and lasts for the programmed duty, counted in ticks. A phase of zero starts the pulse at the wrap. The flag output gives a single-cycle event. By default it marks the trailing edge of the pulse. It can instead mark both edges, or mark the moment the count reaches an independent trigger value, whatever the output is doing.

Software writes period, phase, duty and trigger into shadow registers with one load strobe. The working copy takes the shadow values only at a counter wrap, so no period ever mixes old and new settings. While the block is stopped, the working copy follows the shadow at once. A polarity select inverts the output, and a force control drives the pin to a fixed level whatever the compare logic produces.

Top module: `pwmps_top`

## Requirements
- R1: The counter counts 0,1,…,P-1 and then returns to 0, advancing by one per tick. A period value of 0 acts as 1. `wrap_o` is high in the cycle whose tick moves the count from P-1 to 0.
- R2: With global divisor field G (8 bits, divide by G+1, 1 to 256) and channel divisor field C (4 bits, divide by C+1, 1 to 16), a tick occurs every (G+1)·(C+1) clocks while the block runs.
- R3: The pulse is active while phase ≤ count < phase+duty, and the active level appears in the same cycle as that count. With phase 0 the pulse begins at the wrap.
- R4: When duty is nonzero and smaller than the period, and phase+duty exceeds the period, `cfg_err_o` is 1 and the pulse is cut off at the end of the period. Otherwise `cfg_err_o` is 0.
- R5: A duty of 0 keeps the output inactive for the whole period. A duty equal to or greater than the period keeps it active for the whole period.
- R6: When `inv_i` = 0 the active level is 1. When `inv_i` = 1 the active level is 0.
- R7: When `flag_sel_i` = 2'b00, `flag_o` pulses for one cycle in the cycle the pulse goes inactive. When `flag_sel_i` = 2'b01, it pulses on both the active-going and the inactive-going change.
- R8: When `flag_sel_i` is 2'b10 or 2'b11, `flag_o` pulses for one cycle in the cycle the count becomes equal to the trigger value, independent of the output edges.
- R9: While `force_i` = 1, `pwm_o` equals `force_lvl_i`. Once `force_i` returns to 0, the compare result is visible again.
- R10: `load_i` copies the period, phase, duty and trigger inputs into shadow registers. The working values take the shadow values at the next wrap, or at every clock while `run_i` = 0.
- R11: After reset, `cnt_o` = 0, `wrap_o` = 0, `flag_o` = 0, and the output is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 lets the timebase count; 0 holds the count at 0 |
| gdiv_i | input | 8 | Global prescaler field, divides by value+1 |
| cdiv_i | input | 4 | Channel prescaler field, divides by value+1 |
| load_i | input | 1 | Strobe that writes the four shadow registers |
| period_i | input | 16 | Period in ticks |
| phase_i | input | 16 | Count at which the pulse begins |
| duty_i | input | 16 | Pulse length in ticks |
| trig_i | input | 16 | Count at which the flag fires in trigger mode |
| inv_i | input | 1 | 0 gives an active-high output, 1 gives an active-low output |
| flag_sel_i | input | 2 | 00 trailing edge, 01 both edges, 1x trigger compare |
| force_i | input | 1 | Overrides the output with `force_lvl_i` |
| force_lvl_i | input | 1 | Level driven while forced |
| cnt_o | output | 16 | Shared timebase count |
| wrap_o | output | 1 | Period wrap strobe |
| pwm_o | output | 1 | PWM pin level |
| flag_o | output | 1 | Single-cycle flag event |
| cfg_err_o | output | 1 | Working phase/duty overrun the period |

## Verification
The main function is tried with five kinds of window:
- A pulse offset from the wrap, which tells a correct start count from one shifted by a cycle.
- A pulse beginning at the wrap, which shows whether the edge that spans the period boundary is produced.
- An inverted window, which separates the polarity logic from the compare logic.
- A window whose end runs past the period, which shows whether the pulse is clipped and the error raised.
- Zero and oversized duties, which test the full-inactive and full-active limits.

Further tests check that a reload written mid-period stays out of the output until the wrap, that the trigger flag fires at its own count rather than at an edge, and that the spacing of count changes matches the product of the two divisors.

// File: rtl/pwmps_pkg.sv
package pwmps_pkg;
  typedef enum logic [1:0] {
    FLG_TRAIL = 2'b00,
    FLG_BOTH  = 2'b01,
    FLG_TRIG  = 2'b10,
    FLG_TRIG2 = 2'b11
  } flag_sel_e;
endpackage

// File: rtl/pwmps_prescale.sv
module pwmps_prescale #(
  parameter int GW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [GW-1:0] gdiv_i,
  input  logic [CW-1:0] cdiv_i,
  output logic          tick_o
);
  logic [GW-1:0] gcnt_q;
  logic [CW-1:0] ccnt_q;
  logic          gstep;

  assign gstep  = run_i && (gcnt_q == gdiv_i);
  assign tick_o = gstep && (ccnt_q == cdiv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      ccnt_q <= '0;
    end else if (!run_i) begin
      gcnt_q <= '0;
      ccnt_q <= '0;
    end else if (gstep) begin
      gcnt_q <= '0;
      if (ccnt_q == cdiv_i) ccnt_q <= '0;
      else                  ccnt_q <= ccnt_q + 1'b1;
    end else begin
      gcnt_q <= gcnt_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && gdiv_i != '0) |=> (!tick_o || gdiv_i == '0)); // R2
endmodule

// File: rtl/pwmps_shadow.sv
module pwmps_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         commit_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] ph_i,
  input  logic [W-1:0] du_i,
  input  logic [W-1:0] tr_i,
  output logic [W-1:0] per_a,
  output logic [W-1:0] ph_a,
  output logic [W-1:0] du_a,
  output logic [W-1:0] tr_a,
  output logic [W-1:0] per_s,
  output logic [W-1:0] ph_s,
  output logic [W-1:0] du_s,
  output logic [W-1:0] tr_s
);
  logic [W-1:0] per_sh, ph_sh, du_sh, tr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh <= '0; ph_sh <= '0; du_sh <= '0; tr_sh <= '0;
    end else if (load_i) begin
      per_sh <= per_i; ph_sh <= ph_i; du_sh <= du_i; tr_sh <= tr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a <= '0; ph_a <= '0; du_a <= '0; tr_a <= '0;
    end else if (commit_i) begin
      per_a <= per_sh; ph_a <= ph_sh; du_a <= du_sh; tr_a <= tr_sh;
    end
  end

  // values the compare logic must use for the count being entered
  assign per_s = commit_i ? per_sh : per_a;
  assign ph_s  = commit_i ? ph_sh  : ph_a;
  assign du_s  = commit_i ? du_sh  : du_a;
  assign tr_s  = commit_i ? tr_sh  : tr_a;

  AST_WORKING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(du_a) && $stable(ph_a) && $stable(per_a))); // R10
endmodule

// File: rtl/pwmps_timebase.sv
module pwmps_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] term;

  assign term   = (per_i == '0) ? '0 : per_i - 1'b1;
  assign wrap_o = tick_i && (cnt_q >= term);
  assign nxt_o  = wrap_o ? '0 : cnt_q + 1'b1;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= term)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/pwmps_channel.sv
module pwmps_channel
  import pwmps_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         commit_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] per_s,
  input  logic [W-1:0] ph_s,
  input  logic [W-1:0] du_s,
  input  logic [W-1:0] tr_s,
  input  logic [W-1:0] per_a,
  input  logic [W-1:0] ph_a,
  input  logic [W-1:0] du_a,
  input  flag_sel_e    fsel_i,
  input  logic         inv_i,
  input  logic         force_i,
  input  logic         force_lvl_i,
  output logic         pwm_o,
  output logic         flag_o,
  output logic         err_o
);
  localparam int SW = W + 1;

  logic [W-1:0]  c_next;
  logic [SW-1:0] end_s, end_a, lim_s;
  logic          act_d, act_q, flag_q;
  logic          lead, trail, hit;

  assign c_next = run_i ? nxt_i : '0;
  assign end_s  = {1'b0, ph_s} + {1'b0, du_s};
  assign lim_s  = (end_s > {1'b0, per_s}) ? {1'b0, per_s} : end_s;

  always_comb begin
    if (du_s == '0)        act_d = 1'b0;
    else if (du_s >= per_s) act_d = 1'b1;
    else act_d = (c_next >= ph_s) && ({1'b0, c_next} < lim_s);
  end

  assign lead  = act_d && !act_q;
  assign trail = !act_d && act_q;
  assign hit   = (c_next == tr_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (!run_i) begin
      act_q  <= act_d;
      flag_q <= 1'b0;
    end else if (tick_i) begin
      act_q <= act_d;
      unique case (fsel_i)
        FLG_TRAIL: flag_q <= trail;
        FLG_BOTH:  flag_q <= trail || lead;
        default:   flag_q <= hit;
      endcase
    end else begin
      flag_q <= 1'b0;
    end
  end

  assign end_a  = {1'b0, ph_a} + {1'b0, du_a};
  assign err_o  = (du_a != '0) && (du_a < per_a) && (end_a > {1'b0, per_a});
  assign pwm_o  = force_i ? force_lvl_i : (act_q ^ inv_i);
  assign flag_o = flag_q;

  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !commit_i && du_a == '0) |=> !act_q); // R5
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !commit_i && du_a != '0 && du_a >= per_a) |=> act_q); // R5
  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_i)); // R7
endmodule

// File: rtl/pwmps_top.sv
module pwmps_top
  import pwmps_pkg::*;
#(
  parameter int W  = 16,
  parameter int GW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [GW-1:0] gdiv_i,
  input  logic [CW-1:0] cdiv_i,
  input  logic          load_i,
  input  logic [W-1:0]  period_i,
  input  logic [W-1:0]  phase_i,
  input  logic [W-1:0]  duty_i,
  input  logic [W-1:0]  trig_i,
  input  logic          inv_i,
  input  logic [1:0]    flag_sel_i,
  input  logic          force_i,
  input  logic          force_lvl_i,
  output logic [W-1:0]  cnt_o,
  output logic          wrap_o,
  output logic          pwm_o,
  output logic          flag_o,
  output logic          cfg_err_o
);
  logic         tick, wrap, commit;
  logic [W-1:0] nxt;
  logic [W-1:0] per_a, ph_a, du_a, tr_a;
  logic [W-1:0] per_s, ph_s, du_s, tr_s;

  assign commit = wrap || !run_i;
  assign wrap_o = wrap;

  pwmps_prescale #(.GW(GW), .CW(CW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .gdiv_i(gdiv_i), .cdiv_i(cdiv_i), .tick_o(tick));

  pwmps_shadow #(.W(W)) u_shd (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .commit_i(commit),
    .per_i(period_i), .ph_i(phase_i), .du_i(duty_i), .tr_i(trig_i),
    .per_a(per_a), .ph_a(ph_a), .du_a(du_a), .tr_a(tr_a),
    .per_s(per_s), .ph_s(ph_s), .du_s(du_s), .tr_s(tr_s));

  pwmps_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(tick),
    .per_i(per_a), .cnt_o(cnt_o), .nxt_o(nxt), .wrap_o(wrap));

  pwmps_channel #(.W(W)) u_ch (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(tick),
    .commit_i(commit), .nxt_i(nxt),
    .per_s(per_s), .ph_s(ph_s), .du_s(du_s), .tr_s(tr_s),
    .per_a(per_a), .ph_a(ph_a), .du_a(du_a),
    .fsel_i(flag_sel_e'(flag_sel_i)), .inv_i(inv_i),
    .force_i(force_i), .force_lvl_i(force_lvl_i),
    .pwm_o(pwm_o), .flag_o(flag_o), .err_o(cfg_err_o));

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (cnt_o == '0 && !flag_o)); // R11
endmodule

// File: tb/sim_pwmps_top.sv
`timescale 1ns/1ps
module sim_pwmps_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [7:0]  gdiv_i = '0;
  logic [3:0]  cdiv_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] period_i = '0, phase_i = '0, duty_i = '0, trig_i = '0;
  logic        inv_i = 1'b0;
  logic [1:0]  flag_sel_i = '0;
  logic        force_i = 1'b0, force_lvl_i = 1'b0;
  logic [15:0] cnt_o;
  logic        wrap_o, pwm_o, flag_o, cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwmps_top u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(int c, int ph, int du, int pe);
    int lim;
    if (du == 0) return 1'b0;
    if (du >= pe) return 1'b1;
    lim = (ph + du > pe) ? pe : ph + du;
    return (c >= ph) && (c < lim);
  endfunction

  task automatic start_cfg(input int pe, ph, du, tr, input bit pol, input logic [1:0] md);
    @(negedge clk);
    run_i = 0; period_i = 16'(pe); phase_i = 16'(ph); duty_i = 16'(du);
    trig_i = 16'(tr); inv_i = pol; flag_sel_i = md; load_i = 1;
    @(negedge clk); load_i = 0;
    @(negedge clk); run_i = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cfg(input int pe, ph, du, tr, input bit pol,
                         input logic [1:0] md, input bit exp_err, input string req);
    bit a, prev, ef;
    start_cfg(pe, ph, du, tr, pol, md);
    prev = win(cnt_o, ph, du, pe);
    for (int i = 0; i < 3 * pe; i++) begin
      @(negedge clk);
      a = win(cnt_o, ph, du, pe);
      chk(pwm_o == (a ^ pol), {req, " pwm"}, pwm_o, a ^ pol);
      if (md == 2'b00)      ef = prev && !a;
      else if (md == 2'b01) ef = prev != a;
      else                  ef = (cnt_o == tr);
      chk(flag_o == ef, {req, " flag"}, flag_o, ef);
      chk(wrap_o == (cnt_o == pe - 1), "R1 wrap", wrap_o, cnt_o == pe - 1);
      chk(cfg_err_o == exp_err, {req, " err"}, cfg_err_o, exp_err);
      prev = a;
    end
  endtask

  task automatic t_reset;
    chk(cnt_o == 0, "R11 cnt", cnt_o, 0);
    chk(pwm_o == 0, "R11 pwm", pwm_o, 0);
    chk(flag_o == 0, "R11 flag", flag_o, 0);
    chk(wrap_o == 0, "R11 wrap", wrap_o, 0);
  endtask

  task automatic t_reload;
    int du = 3;
    start_cfg(10, 0, 3, 0, 0, 2'b00);
    while (cnt_o != 5) @(negedge clk);
    duty_i = 7; load_i = 1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      load_i = 0;
      if (cnt_o == 0) du = 7;
      chk(pwm_o == win(cnt_o, 0, du, 10), "R10 reload at wrap", pwm_o, win(cnt_o, 0, du, 10));
    end
  endtask

  task automatic t_force;
    start_cfg(10, 2, 4, 0, 0, 2'b00);
    force_i = 1; force_lvl_i = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); chk(pwm_o == 0, "R9 force low", pwm_o, 0);
    end
    force_lvl_i = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); chk(pwm_o == 1, "R9 force high", pwm_o, 1);
    end
    force_i = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(pwm_o == win(cnt_o, 2, 4, 10), "R9 release", pwm_o, win(cnt_o, 2, 4, 10));
    end
  endtask

  task automatic t_prescale;
    int last, gap;
    gdiv_i = 8'd1; cdiv_i = 4'd2;
    start_cfg(10, 0, 5, 0, 0, 2'b00);
    last = cnt_o;
    while (cnt_o == last) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      last = cnt_o; gap = 0;
      while (cnt_o == last && gap < 100) begin @(negedge clk); gap++; end
      chk(gap == 6, "R2 tick spacing", gap, 6);
    end
    gdiv_i = '0; cdiv_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    run_cfg(10, 2, 3, 0, 0, 2'b00, 0, "R3 offset pulse");
    run_cfg(10, 0, 4, 0, 0, 2'b01, 0, "R7 phase0 both");
    run_cfg(10, 3, 4, 0, 1, 2'b00, 0, "R6 inverted");
    run_cfg(12, 2, 5, 7, 0, 2'b10, 0, "R8 trigger");
    run_cfg(10, 8, 5, 0, 0, 2'b00, 1, "R4 overrun clip");
    run_cfg(10, 3, 0, 0, 0, 2'b01, 0, "R5 zero duty");
    run_cfg(10, 3, 12, 0, 0, 2'b01, 0, "R5 full duty");
    t_reload;
    t_force;
    t_prescale;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule